// File: doc/BRIEF.md
# Watchdog Timer with Selectable Register Personality

A watchdog peripheral that sits on an APB slave port and decodes a 4 KiB register window. A down-counter runs while the interrupt-enable bit is set and the count-enable input is high. When it runs out, it raises an interrupt flag and reloads itself. If it runs out a second time before software has cleared the flag, and reset generation is enabled, it raises a reset request. That request stays raised until the block is reset. A key-protected lock guards all other registers against stray writes. An integration-test mode lets the two outputs be driven straight from a register.

The build parameter `VARIANT` selects one of two register personalities. In the alternate personality the identification words differ, and the integration-test and interrupt-clear offsets are dead. A stall-test word at 0x418 reads as zero. The interrupt-enable bit also becomes sticky: once it is set, control writes are thrown away until reset.

Accesses take zero wait states. Writes commit on the clock edge that ends the access phase, and read data is valid during the access phase. Data offsets: reload value 0x000, current count 0x004, control 0x008, clear 0x00C, raw flag 0x010, masked flag 0x014, stall test 0x418, lock 0xC00, test control 0xF00, test output 0xF04, identification 0xFD0 to 0xFFC.

Top module: `wdog_apb`

## Requirements
- R1: When control bit 0 (interrupt enable) is 1 and `cnt_en_i` is high on a clock, the count falls by one. On such a clock with the count at zero, it instead reloads from the reload value and sets the raw flag (bit 0 at 0x010). With either condition low the count holds.
- R2: A write to 0x000 sets the reload value and the current count to the written data, both visible on the next read.
- R3: An expiry while the raw flag is already 1 and control bit 1 (reset enable) is 1 raises `rst_req_o`, which then stays high until `rst_ni` is asserted.
- R4: The word at 0x014 reads raw flag AND interrupt enable in bit 0. Outside integration-test mode, `irq_o` equals that value.
- R5: In the default personality, any write to 0x00C clears the raw flag and reloads the count from the reload value.
- R6: Writing 0x1ACCE551 to 0xC00 unlocks; any other value locks. 0xC00 reads 1 when locked and 0 when unlocked. While locked, writes to every other offset have no effect.
- R7: In the default personality, with bit 0 of 0xF00 set, `irq_o` follows bit 1 and `rst_req_o` follows bit 0 of the test output word at 0xF04. 0xF00 reads back its bit 0, and 0xF04 reads zero.
- R8: In the alternate personality, a control write is discarded while interrupt enable is 1. In the default personality, control is always writable.
- R9: In the alternate personality, 0x00C, 0xF00 and 0xF04 read zero and writes to them have no effect. In both personalities, 0x418 reads zero.
- R10: The twelve words at 0xFD0 to 0xFFC read, in address order, 04,00,00,00,24,B8,1B,00,0D,F0,05,B1 in the default personality, and 00,00,00,00,05,18,18,01,0D,F0,05,B1 in the alternate one.
- R11: Unmapped offsets read zero and ignore writes. The current count at 0x004 is read-only.
- R12: After reset the reload value and count are all ones, control, raw flag and lock are 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable, one decrement per high clock |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Reset request |

## Verification
Random reload values and tick counts drive the count through zero, once and more than once. A counter that reloads on the wrong tick, or misses the wrap at zero, shows a wrong count, flag or reset request. Directed cases cover the following:
- A wrong lock key must leave the reload value untouched. A lock that compares too few bits, or never blocks writes, changes it.
- In the alternate personality, a second control write must not clear the enable bit, and the clear and test offsets must be dead. A build that ignores the personality lets the flag clear or the test outputs leak through.
- Every identification word is read in both personalities. A swapped table or a shifted index shows up on the first word that differs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NUM_ID = 12;

  localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_VALUE = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_MSK   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_STALL = 12'h418;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'hC00;
  localparam logic [ADDR_W-1:0] OFF_ITC   = 12'hF00;
  localparam logic [ADDR_W-1:0] OFF_ITO   = 12'hF04;
  localparam logic [ADDR_W-1:0] OFF_ID0   = 12'hFD0;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic res_en;
    logic int_en;
  } ctrl_t;

  function automatic logic [7:0] id_word(input bit alt, input int idx);
    logic [7:0] w;
    w = 8'h00;
    if (idx >= 8) begin
      case (idx)
        8:  w = 8'h0D;
        9:  w = 8'hF0;
        10: w = 8'h05;
        default: w = 8'hB1;
      endcase
    end else if (alt) begin
      case (idx)
        4: w = 8'h05;
        5: w = 8'h18;
        6: w = 8'h18;
        7: w = 8'h01;
        default: w = 8'h00;
      endcase
    end else begin
      case (idx)
        0: w = 8'h04;
        4: w = 8'h24;
        5: w = 8'hB8;
        6: w = 8'h1B;
        default: w = 8'h00;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter bit VARIANT = 1'b0,
  parameter int CNT_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic [CNT_W-1:0]  load_i,
  input  logic [CNT_W-1:0]  value_i,
  input  logic              raw_i,
  output ctrl_t             ctrl_o,
  output logic              lock_o,
  output logic              itc_o,
  output logic [1:0]        ito_o,
  output logic              wr_load_o,
  output logic              wr_clr_o
);
  localparam bit HAS_IT    = !VARIANT;
  localparam bit HAS_CLR   = !VARIANT;
  localparam int WORD_W    = ADDR_W - 2;
  localparam int ID_BASE   = int'(OFF_ID0 >> 2);

  logic [WORD_W-1:0] word;
  logic acc, wr, wr_ok;
  logic hit_load, hit_ctrl, hit_clr, hit_lock, hit_itc, hit_ito;
  ctrl_t ctrl_q;
  logic lock_q, itc_q;
  logic [1:0] ito_q;

  assign word  = paddr_i[ADDR_W-1:2];
  assign acc   = psel_i & penable_i;
  assign wr    = acc & pwrite_i;

  assign hit_load = (word == OFF_LOAD[ADDR_W-1:2]);
  assign hit_ctrl = (word == OFF_CTRL[ADDR_W-1:2]);
  assign hit_clr  = HAS_CLR && (word == OFF_CLR[ADDR_W-1:2]);
  assign hit_lock = (word == OFF_LOCK[ADDR_W-1:2]);
  assign hit_itc  = HAS_IT && (word == OFF_ITC[ADDR_W-1:2]);
  assign hit_ito  = HAS_IT && (word == OFF_ITO[ADDR_W-1:2]);

  // lock gates every write except its own
  assign wr_ok = wr & (~lock_q | hit_lock);

  assign wr_load_o = wr_ok & hit_load;
  assign wr_clr_o  = wr_ok & hit_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
      itc_q  <= 1'b0;
      ito_q  <= '0;
    end else begin
      if (wr_ok && hit_ctrl && !(VARIANT && ctrl_q.int_en))
        ctrl_q <= ctrl_t'(pwdata_i[1:0]);
      if (wr && hit_lock)
        lock_q <= (pwdata_i != UNLOCK_KEY);
      if (wr_ok && hit_itc)
        itc_q <= pwdata_i[0];
      if (wr_ok && hit_ito)
        ito_q <= pwdata_i[1:0];
    end
  end

  assign ctrl_o = ctrl_q;
  assign lock_o = lock_q;
  assign itc_o  = itc_q;
  assign ito_o  = ito_q;

  always_comb begin
    int id_idx;
    prdata_o = '0;
    id_idx   = int'(word) - ID_BASE;
    if (acc && !pwrite_i) begin
      if (id_idx >= 0 && id_idx < NUM_ID) begin
        prdata_o = DATA_W'(id_word(VARIANT, id_idx));
      end else begin
        case (word)
          OFF_LOAD[ADDR_W-1:2]:  prdata_o = DATA_W'(load_i);
          OFF_VALUE[ADDR_W-1:2]: prdata_o = DATA_W'(value_i);
          OFF_CTRL[ADDR_W-1:2]:  prdata_o = DATA_W'(ctrl_q);
          OFF_RAW[ADDR_W-1:2]:   prdata_o = DATA_W'(raw_i);
          OFF_MSK[ADDR_W-1:2]:   prdata_o = DATA_W'(raw_i & ctrl_q.int_en);
          OFF_LOCK[ADDR_W-1:2]:  prdata_o = DATA_W'(lock_q);
          OFF_ITC[ADDR_W-1:2]:   prdata_o = HAS_IT ? DATA_W'(itc_q) : '0;
          default:               prdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              int_en_i,
  input  logic              res_en_i,
  input  logic              wr_load_i,
  input  logic              wr_clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  value_o,
  output logic              raw_o,
  output logic              rst_o,
  output logic              expire_o
);
  logic [CNT_W-1:0] load_q, value_q;
  logic raw_q, rst_q, tick, expire;

  assign tick   = cnt_en_i & int_en_i;
  assign expire = tick & (value_q == '0) & ~wr_load_i & ~wr_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q  <= '1;
      value_q <= '1;
      raw_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (wr_load_i) begin
        load_q  <= wdata_i[CNT_W-1:0];
        value_q <= wdata_i[CNT_W-1:0];
      end else if (wr_clr_i || expire) begin
        value_q <= load_q;
      end else if (tick) begin
        value_q <= value_q - 1'b1;
      end

      if (wr_clr_i)    raw_q <= 1'b0;
      else if (expire) raw_q <= 1'b1;

      // second expiry with flag still pending
      if (expire && raw_q && res_en_i) rst_q <= 1'b1;
    end
  end

  assign load_o   = load_q;
  assign value_o  = value_q;
  assign raw_o    = raw_q;
  assign rst_o    = rst_q;
  assign expire_o = expire;
endmodule

// File: rtl/wdog_out.sv
module wdog_out (
  input  logic       itc_i,
  input  logic [1:0] ito_i,
  input  logic       raw_i,
  input  logic       int_en_i,
  input  logic       rst_i,
  output logic       irq_o,
  output logic       rst_req_o
);
  always_comb begin
    if (itc_i) begin
      irq_o     = ito_i[1];
      rst_req_o = ito_i[0];
    end else begin
      irq_o     = raw_i & int_en_i;
      rst_req_o = rst_i;
    end
  end
endmodule

// File: rtl/wdog_apb.sv
module wdog_apb
  import wdog_pkg::*;
#(
  parameter bit VARIANT = 1'b0,
  parameter int CNT_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  ctrl_t ctrl;
  logic lock_on, itc, wr_load, wr_clr, raw_flag, rst_flag, expire;
  logic [1:0] ito;
  logic [CNT_W-1:0] load_val, cnt_val;

  wdog_regs #(.VARIANT(VARIANT), .CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .prdata_o  (prdata_o),
    .load_i    (load_val),
    .value_i   (cnt_val),
    .raw_i     (raw_flag),
    .ctrl_o    (ctrl),
    .lock_o    (lock_on),
    .itc_o     (itc),
    .ito_o     (ito),
    .wr_load_o (wr_load),
    .wr_clr_o  (wr_clr)
  );

  wdog_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_en_i  (cnt_en_i),
    .int_en_i  (ctrl.int_en),
    .res_en_i  (ctrl.res_en),
    .wr_load_i (wr_load),
    .wr_clr_i  (wr_clr),
    .wdata_i   (pwdata_i),
    .load_o    (load_val),
    .value_o   (cnt_val),
    .raw_o     (raw_flag),
    .rst_o     (rst_flag),
    .expire_o  (expire)
  );

  wdog_out u_out (
    .itc_i     (itc),
    .ito_i     (ito),
    .raw_i     (raw_flag),
    .int_en_i  (ctrl.int_en),
    .rst_i     (rst_flag),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdog_apb_chk.sv
module wdog_apb_chk #(
  parameter bit VARIANT = 1'b0,
  parameter int CNT_W   = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             expire,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] cnt_val,
  input logic             raw_flag,
  input logic             rst_flag,
  input logic             int_en,
  input logic             itc,
  input logic             lock_on,
  input logic             wr_load,
  input logic             irq_o
);
  assert_expire_reload_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (cnt_val == $past(load_val)) && raw_flag);

  assert_rst_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_flag |=> rst_flag);

  assert_rst_needs_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_flag) |-> $past(raw_flag));

  assert_irq_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!itc && !int_en) |-> !irq_o);

  assert_lock_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_on |-> !wr_load);

  generate
    if (VARIANT) begin : g_var
      assert_sticky_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_en |=> int_en);
      assert_no_itest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !itc);
    end
  endgenerate
endmodule

bind wdog_apb wdog_apb_chk #(.VARIANT(VARIANT), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .expire   (expire),
  .load_val (load_val),
  .cnt_val  (cnt_val),
  .raw_flag (raw_flag),
  .rst_flag (rst_flag),
  .int_en   (ctrl.int_en),
  .itc      (itc),
  .lock_on  (lock_on),
  .wr_load  (wr_load),
  .irq_o    (irq_o)
);

// File: tb/wdog_apb_tb.sv
`timescale 1ns/1ps
module wdog_apb_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic which = 1'b0;
  logic [31:0] rd_d, rd_v;
  logic irq_d, irq_v, rr_d, rr_v;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_apb #(.VARIANT(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en),
    .psel_i(psel & ~which), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(rd_d),
    .irq_o(irq_d), .rst_req_o(rr_d));

  wdog_apb #(.VARIANT(1'b1)) u_dut_var (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en),
    .psel_i(psel & which), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(rd_v),
    .irq_o(irq_v), .rst_req_o(rr_v));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s dut=%0d act=%h exp=%h", req, which, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1;
    d = which ? rd_v : rd_d;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk); cnt_en = 1;
      repeat (n) @(negedge clk);
      cnt_en = 0;
    end
  endtask

  function automatic logic cur_irq(); return which ? irq_v : irq_d; endfunction
  function automatic logic cur_rr();  return which ? rr_v  : rr_d;  endfunction

  function automatic int exp_val(int l, int k); return l - (k % (l + 1)); endfunction
  function automatic int exp_wraps(int l, int k); return k / (l + 1); endfunction

  function automatic logic [7:0] exp_id(bit alt, int i);
    logic [7:0] tbl_d [12] = '{8'h04,8'h00,8'h00,8'h00,8'h24,8'hB8,8'h1B,8'h00,8'h0D,8'hF0,8'h05,8'hB1};
    logic [7:0] tbl_v [12] = '{8'h00,8'h00,8'h00,8'h00,8'h05,8'h18,8'h18,8'h01,8'h0D,8'hF0,8'h05,8'hB1};
    return alt ? tbl_v[i] : tbl_d[i];
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    for (int m = 0; m < 2; m++) begin
      which = m[0];
      do_reset();
      // R12 reset state
      rd(12'h000, r); check("R12 load", r, 32'hFFFF_FFFF);
      rd(12'h004, r); check("R12 value", r, 32'hFFFF_FFFF);
      rd(12'h008, r); check("R12 ctrl", r, 0);
      rd(12'h010, r); check("R12 raw", r, 0);
      rd(12'hC00, r); check("R12 lock", r, 0);
      check("R12 irq", cur_irq(), 0);
      check("R12 rst", cur_rr(), 0);

      // R1 R2 R3 R4 random count trials
      for (int t = 0; t < 20; t++) begin
        int l, k, wraps;
        logic [1:0] c;
        l = 1 + int'($urandom_range(19));
        k = int'($urandom_range(60));
        c = ($urandom_range(1) != 0) ? 2'b11 : 2'b01;
        do_reset();
        wr(12'h000, l);
        rd(12'h004, r); check("R2 load to value", r, l);
        wr(12'h008, {30'b0, c});
        ticks(k);
        wraps = exp_wraps(l, k);
        rd(12'h004, r); check("R1 count", r, exp_val(l, k));
        rd(12'h010, r); check("R1 raw", r, (wraps >= 1) ? 1 : 0);
        rd(12'h014, r); check("R4 masked", r, (wraps >= 1) ? 1 : 0);
        check("R4 irq", cur_irq(), (wraps >= 1) ? 1 : 0);
        check("R3 rst_req", cur_rr(), (wraps >= 2 && c[1]) ? 1 : 0);
      end

      // R1 hold while count enable high but interrupt enable low
      do_reset();
      wr(12'h000, 9);
      ticks(5);
      rd(12'h004, r); check("R1 hold", r, 9);

      // R3 sticky until reset
      wr(12'h008, 3);
      ticks(20);
      check("R3 raised", cur_rr(), 1);
      ticks(3);
      check("R3 sticky", cur_rr(), 1);

      // R5 / R9 interrupt clear
      do_reset();
      wr(12'h000, 4);
      wr(12'h008, 1);
      ticks(7);
      rd(12'h004, r); check("R1 after wrap", r, 2);
      wr(12'h00C, 32'h5A);
      rd(12'h010, r); check(which ? "R9 clr dead raw" : "R5 clr raw", r, which ? 1 : 0);
      rd(12'h004, r); check(which ? "R9 clr dead value" : "R5 clr reload", r, which ? 2 : 4);
      rd(12'h00C, r); check("R9 clr reads zero", r, 0);

      // R4 mask off (default only, variant control is sticky)
      if (!which) begin
        wr(12'h008, 0);
        wr(12'h000, 4);
        wr(12'h008, 1);
        ticks(5);
        wr(12'h008, 0);
        rd(12'h010, r); check("R4 raw kept", r, 1);
        rd(12'h014, r); check("R4 masked off", r, 0);
        check("R4 irq off", cur_irq(), 0);
      end

      // R8 control writability
      do_reset();
      wr(12'h008, 1);
      wr(12'h008, 3);
      rd(12'h008, r); check("R8 ctrl second", r, which ? 1 : 3);
      wr(12'h008, 0);
      rd(12'h008, r); check("R8 ctrl clear", r, which ? 1 : 0);

      // R6 lock
      do_reset();
      wr(12'h000, 20);
      wr(12'hC00, 32'h1ACC_E550);
      rd(12'hC00, r); check("R6 locked", r, 1);
      wr(12'h000, 7);
      rd(12'h000, r); check("R6 load blocked", r, 20);
      wr(12'h008, 1);
      rd(12'h008, r); check("R6 ctrl blocked", r, 0);
      wr(12'hC00, 32'h1ACC_E551);
      rd(12'hC00, r); check("R6 unlocked", r, 0);
      wr(12'h000, 7);
      rd(12'h000, r); check("R6 load open", r, 7);

      // R7 / R9 integration test
      do_reset();
      wr(12'hF04, 2);
      wr(12'hF00, 1);
      rd(12'hF00, r); check(which ? "R9 itc dead" : "R7 itc read", r, which ? 0 : 1);
      rd(12'hF04, r); check("R7 ito reads zero", r, 0);
      check("R7 irq from test", cur_irq(), which ? 0 : 1);
      check("R7 rst from test", cur_rr(), 0);
      wr(12'hF04, 1);
      check("R7 irq bit1", cur_irq(), 0);
      check("R7 rst bit0", cur_rr(), which ? 0 : 1);
      wr(12'hF00, 0);
      check("R7 back to logic", cur_rr(), 0);

      // R9 stall word, R11 unmapped and read-only
      rd(12'h418, r); check("R9 stall reads zero", r, 0);
      wr(12'h418, 32'hFFFF_FFFF);
      rd(12'h418, r); check("R9 stall ignores write", r, 0);
      rd(12'h800, r); check("R11 unmapped read", r, 0);
      wr(12'h800, 32'h1234);
      rd(12'h000, r); check("R11 unmapped write", r, 32'hFFFF_FFFF);
      wr(12'h004, 32'h123);
      rd(12'h004, r); check("R11 value read-only", r, 32'hFFFF_FFFF);

      // R10 identification words
      for (int i = 0; i < 12; i++) begin
        rd(12'hFD0 + 12'(4 * i), r);
        check("R10 id", r, {24'b0, exp_id(which, i)});
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule